// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a serial EEPROM holding 256 words of 16 bits behind a three-wire slave port: a chip-select, a serial clock and a serial data input, with one serial data output. The port pins are sampled by the system clock, and serial-clock rising edges are found by comparing successive samples. An instruction is a start bit of 1, a two-bit operation code and an eight-bit address. Two of the operations also carry a sixteen-bit data word.

The block supports reading a word, writing a word, erasing a word, writing or erasing the whole array, and enabling or disabling programming. Programming runs as a self-timed cycle whose length is a parameter counted in system-clock cycles. While chip-select is high after a cycle has started, the data output reports whether that cycle is still running. Storage is a plain register array that reset does not clear.

Top module: `ser_eeprom_slave`

## Requirements
- R1: An instruction starts at the first serial-clock rise that samples a 1 on the data input while chip-select is high. Rises that sample 0 before it are ignored. The start bit is followed by a 2-bit operation code and then an 8-bit address, both MSB first.
- R2: The operation codes are 10 for read, 01 for write and 11 for erase word. Code 00 is extended by address bits 7:6: 11 enables programming, 10 erases all words, 01 writes all words and 00 disables programming. Address bits 5:0 are ignored for the extended commands.
- R3: On a read, the data output is 0 from the rise that samples the last address bit. The 16 data bits then follow MSB first, and each bit changes after the serial-clock rise that advances it.
- R4: Write and write-all take 16 data bits, MSB first, after the address. A write stores the word at the given address and leaves other words unchanged.
- R5: Erase word sets the addressed word to FFFF hex. Erase all sets every word to FFFF hex. Write-all stores its data word in every location.
- R6: A programming command takes effect only when chip-select falls after its final bit and before any further serial-clock rise. An extra rise cancels the command.
- R7: Once a programming cycle has started, the data output reads 0 while chip-select is high for PROG_CYCLES system-clock cycles, and reads 1 after that. This status display lasts until the next start bit.
- R8: After reset, programming is disabled. The enable command allows programming commands and the disable command blocks them: memory stays unchanged and no cycle starts.
- R9: If chip-select falls before an instruction is complete, the instruction is dropped and memory is not changed.
- R10: Start bits and instructions received while a programming cycle runs are ignored.
- R11: The data output is 0 whenever chip-select is low, including straight after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins and runs the programming timer |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_i | input | 1 | Chip-select, active high |
| sck_i | input | 1 | Serial clock; the block acts on its rising edges |
| sdi_i | input | 1 | Serial data in, sampled on serial-clock rises |
| sdo_o | output | 1 | Serial data out: read data or ready/busy status |

## Verification
A read bit becomes valid two system-clock edges after the serial-clock rise that advances it. The bench holds each serial-clock phase for four system clocks and samples at the end of the high phase, so every sample falls well after that point. A programming cycle starts three edges after chip-select falls. The bench raises chip-select two cycles later, expects 0 there, and then counts cycles until the output reads 1, allowing two cycles either side of the expected count. Stored words are checked by later reads, whose expected values are queued by the driver and compared in order by the monitor.

// File: rtl/see_pkg.sv
package see_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_DONE,
    ST_ABORT
  } see_state_e;

  typedef enum logic [2:0] {
    CMD_READ,
    CMD_WRITE,
    CMD_ERASE,
    CMD_WREN,
    CMD_WRDIS,
    CMD_ERASE_ALL,
    CMD_WRITE_ALL
  } see_cmd_e;

  // operation code plus the two top address bits select the command
  function automatic see_cmd_e see_decode(input logic [1:0] opc, input logic [1:0] ext);
    see_cmd_e c;
    unique case (opc)
      2'b10:   c = CMD_READ;
      2'b01:   c = CMD_WRITE;
      2'b11:   c = CMD_ERASE;
      default: begin
        unique case (ext)
          2'b11:   c = CMD_WREN;
          2'b10:   c = CMD_ERASE_ALL;
          2'b01:   c = CMD_WRITE_ALL;
          default: c = CMD_WRDIS;
        endcase
      end
    endcase
    return c;
  endfunction

  function automatic logic see_is_prog(input see_cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) ||
           (c == CMD_WRITE_ALL) || (c == CMD_ERASE_ALL);
  endfunction

endpackage

// File: rtl/see_link.sv
// Serial front end: pin sampling, edge detection, instruction shifting.
module see_link
  import see_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic              start_o,
  output logic              exec_o,
  output see_cmd_e          cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rd_bit_o
);

  localparam int LONG_W = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W  = $clog2(LONG_W + 1);

  logic s_cs, s_sck, s_di, p_sck, p_cs;
  logic rise, fall;

  see_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        opc_q, opc_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [DATA_W:0]   rd_sh_q, rd_sh_d;
  logic              load_q, load_d;
  see_cmd_e          cmd_q, cmd_d;
  logic              exec_q, exec_d;
  logic              start_q, start_d;

  // pin sampling
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cs  <= 1'b0;
      s_sck <= 1'b0;
      s_di  <= 1'b0;
      p_sck <= 1'b0;
      p_cs  <= 1'b0;
    end else begin
      s_cs  <= cs_i;
      s_sck <= sck_i;
      s_di  <= sdi_i;
      p_sck <= s_sck;
      p_cs  <= s_cs;
    end
  end

  assign rise = s_sck & ~p_sck & s_cs;
  assign fall = p_cs & ~s_cs;

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    opc_d   = opc_q;
    addr_d  = addr_q;
    data_d  = data_q;
    rd_sh_d = rd_sh_q;
    cmd_d   = cmd_q;
    load_d  = 1'b0;
    exec_d  = 1'b0;
    start_d = 1'b0;
    if (load_q) rd_sh_d = {1'b0, rd_word_i};
    if (fall) begin
      exec_d  = (state_q == ST_DONE);
      state_d = ST_IDLE;
    end else if (rise) begin
      unique case (state_q)
        ST_IDLE: begin
          if (s_di && !busy_i) begin
            state_d = ST_OPC;
            cnt_d   = '0;
            start_d = 1'b1;
          end
        end
        ST_OPC: begin
          opc_d = {opc_q[0], s_di};
          if (cnt_q == CNT_W'(1)) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_ADDR: begin
          addr_d = {addr_q[ADDR_W-2:0], s_di};
          if (cnt_q == CNT_W'(ADDR_W - 1)) begin
            cmd_d = see_decode(opc_q, addr_d[ADDR_W-1 -: 2]);
            cnt_d = '0;
            unique case (cmd_d)
              CMD_READ: begin
                state_d = ST_READ;
                rd_sh_d = '0;
                load_d  = 1'b1;
              end
              CMD_WRITE, CMD_WRITE_ALL: state_d = ST_DATA;
              default:                  state_d = ST_DONE;
            endcase
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          data_d = {data_q[DATA_W-2:0], s_di};
          if (cnt_q == CNT_W'(DATA_W - 1)) state_d = ST_DONE;
          else                             cnt_d   = cnt_q + 1'b1;
        end
        ST_READ:  rd_sh_d = {rd_sh_q[DATA_W-1:0], 1'b0};
        ST_DONE:  state_d = ST_ABORT;
        default:  state_d = ST_ABORT;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      opc_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rd_sh_q <= '0;
      load_q  <= 1'b0;
      cmd_q   <= CMD_READ;
      exec_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      opc_q   <= opc_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      rd_sh_q <= rd_sh_d;
      load_q  <= load_d;
      cmd_q   <= cmd_d;
      exec_q  <= exec_d;
      start_q <= start_d;
    end
  end

  assign start_o  = start_q;
  assign exec_o   = exec_q;
  assign cmd_o    = cmd_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;
  assign rd_bit_o = rd_sh_q[DATA_W];

endmodule

// File: rtl/see_prog.sv
// Write protection, programming timer and status display.
module see_prog
  import see_pkg::*;
#(
  parameter int PROG_CYCLES = 400
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     exec_i,
  input  logic     start_i,
  input  see_cmd_e cmd_i,
  output logic     busy_o,
  output logic     status_o,
  output logic     wen_o,
  output logic     wr_one_o,
  output logic     wr_all_o,
  output logic     wr_ones_o
);

  localparam int TMR_W = $clog2(PROG_CYCLES + 1);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             wen_q, wen_d;
  logic             status_q, status_d;
  logic             go;

  assign busy_o = (tmr_q != '0);
  assign go     = exec_i & wen_q & ~busy_o & see_is_prog(cmd_i);

  always_comb begin
    wen_d    = wen_q;
    tmr_d    = tmr_q;
    status_d = status_q;
    if (exec_i && cmd_i == CMD_WREN)  wen_d = 1'b1;
    if (exec_i && cmd_i == CMD_WRDIS) wen_d = 1'b0;
    if (go)          tmr_d = TMR_W'(PROG_CYCLES);
    else if (busy_o) tmr_d = tmr_q - 1'b1;
    if (go)           status_d = 1'b1;
    else if (start_i) status_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q    <= '0;
      wen_q    <= 1'b0;
      status_q <= 1'b0;
    end else begin
      tmr_q    <= tmr_d;
      wen_q    <= wen_d;
      status_q <= status_d;
    end
  end

  assign status_o  = status_q;
  assign wen_o     = wen_q;
  assign wr_one_o  = go & ((cmd_i == CMD_WRITE) || (cmd_i == CMD_ERASE));
  assign wr_all_o  = go & ((cmd_i == CMD_WRITE_ALL) || (cmd_i == CMD_ERASE_ALL));
  assign wr_ones_o = (cmd_i == CMD_ERASE) || (cmd_i == CMD_ERASE_ALL);

endmodule

// File: rtl/see_store.sv
// Word storage; contents survive reset like a non-volatile array.
module see_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_one_i,
  input  logic              wr_all_i,
  input  logic              wr_ones_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] wval;
  logic [DATA_W-1:0] words [DEPTH];

  assign wval = wr_ones_i ? '1 : wdata_i;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic              hit;
    logic [DATA_W-1:0] word_q;
    assign hit = wr_all_i | (wr_one_i & (waddr_i == ADDR_W'(gi)));
    always_ff @(posedge clk) begin
      if (hit) word_q <= wval;
    end
    assign words[gi] = word_q;
  end

  assign rdata_o = words[raddr_i];

endmodule

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave
  import see_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o
);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              busy, status, wen, wr_one, wr_all, wr_ones;
  logic              start, exec, rd_bit;
  see_cmd_e          cmd;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data, rd_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  see_link #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_link (
    .clk(clk), .rst_n(rst_int_n), .cs_i(cs_i), .sck_i(sck_i), .sdi_i(sdi_i),
    .busy_i(busy), .rd_word_i(rd_word), .start_o(start), .exec_o(exec),
    .cmd_o(cmd), .addr_o(addr), .data_o(data), .rd_bit_o(rd_bit)
  );

  see_prog #(.PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_int_n), .exec_i(exec), .start_i(start), .cmd_i(cmd),
    .busy_o(busy), .status_o(status), .wen_o(wen), .wr_one_o(wr_one),
    .wr_all_o(wr_all), .wr_ones_o(wr_ones)
  );

  see_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .wr_one_i(wr_one), .wr_all_i(wr_all), .wr_ones_i(wr_ones),
    .waddr_i(addr), .wdata_i(data), .raddr_i(addr), .rdata_o(rd_word)
  );

  assign sdo_o = cs_i & (status ? ~busy : rd_bit);

endmodule

// File: rtl/ser_eeprom_slave_chk.sv
module ser_eeprom_slave_chk #(
  parameter int PROG_CYCLES = 400
) (
  input logic clk,
  input logic rst_n,
  input logic cs_i,
  input logic sdo_o,
  input logic busy,
  input logic status,
  input logic wen,
  input logic wr_one,
  input logic wr_all,
  input logic start
);

  localparam int LEN_W = $clog2(PROG_CYCLES + 2);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (busy) len_q <= len_q + 1'b1;
    else           len_q <= '0;
  end

  p_quiet_cs_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |-> !sdo_o);

  p_busy_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && status && busy) |-> !sdo_o);

  p_busy_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len_q == LEN_W'(PROG_CYCLES)));

  p_locked_no_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_one || wr_all) |-> wen);

  p_store_starts_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_one || wr_all) |=> busy);

  p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

bind ser_eeprom_slave ser_eeprom_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .cs_i(cs_i), .sdo_o(sdo_o), .busy(busy),
  .status(status), .wen(wen), .wr_one(wr_one), .wr_all(wr_all), .start(start)
);

// File: tb/test_ser_eeprom_slave.sv
module test_ser_eeprom_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int PROG       = 400;

  logic clk = 1'b0;
  logic rst_n, cs, sck, sdi;
  logic sdo;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ser_eeprom_slave #(.PROG_CYCLES(PROG)) i_ser_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    string       req;
    logic [15:0] val;
  } item_t;
  item_t       exp_q[$];
  logic [15:0] act_q[$];
  event        got_word;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compare read words against queued expectations
  initial begin
    forever begin
      @(got_word);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        item_t       e;
        logic [15:0] a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        check(e.req, {16'h0, a}, {16'h0, e.val});
      end
    end
  end

  task automatic bit_out(input logic b, output logic smp);
    @(negedge clk);
    sdi = b;
    sck = 1'b0;
    repeat (HALF - 1) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    smp = sdo;
    sck = 1'b0;
  endtask

  task automatic header(input logic [1:0] opc, input logic [7:0] a, output logic last);
    logic s;
    @(negedge clk);
    cs = 1'b1;
    bit_out(1'b1, s);
    for (int i = 1; i >= 0; i--) bit_out(opc[i], s);
    for (int i = 7; i >= 0; i--) bit_out(a[i], s);
    last = s;
  endtask

  task automatic send_data(input logic [15:0] d, input int nbits);
    logic s;
    for (int i = 15; i > 15 - nbits; i--) bit_out(d[i], s);
  endtask

  task automatic cs_off();
    @(negedge clk);
    sck = 1'b0;
    cs  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_ready(input string req, input bit chk_len);
    int n;
    @(negedge clk);
    cs = 1'b1;
    @(negedge clk);
    check({req, " busy shows 0"}, {31'h0, sdo}, 32'h0);
    n = 0;
    while (sdo !== 1'b1 && n < 3 * PROG) begin
      @(negedge clk);
      n++;
    end
    check({req, " ready shows 1"}, {31'h0, sdo}, 32'h1);
    if (chk_len)
      check({req, " busy length"}, {31'h0, (n >= PROG - 4) && (n <= PROG)}, 32'h1);
    cs_off();
  endtask

  task automatic do_ext(input logic [1:0] ext, input logic [5:0] low);
    logic s;
    header(2'b00, {ext, low}, s);
    cs_off();
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d, input bit en);
    logic s;
    header(2'b01, a, s);
    send_data(d, 16);
    cs_off();
    if (en) wait_ready("R7 write", 1'b1);
  endtask

  task automatic do_read(input logic [7:0] a, input logic [15:0] exp, input string req,
                         input int lead);
    logic        s;
    logic [15:0] w;
    item_t       it;
    it.req = req;
    it.val = exp;
    exp_q.push_back(it);
    @(negedge clk);
    cs = 1'b1;
    for (int i = 0; i < lead; i++) bit_out(1'b0, s);
    header(2'b10, a, s);
    check("R3 dummy bit", {31'h0, s}, 32'h0);
    for (int i = 15; i >= 0; i--) begin
      bit_out(1'b0, s);
      w[i] = s;
    end
    act_q.push_back(w);
    ->got_word;
    cs_off();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic s;
    rst_n = 1'b0;
    cs    = 1'b0;
    sck   = 1'b0;
    sdi   = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 reset output", {31'h0, sdo}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 idle output", {31'h0, sdo}, 32'h0);

    // R2 enable with arbitrary low address bits
    do_ext(2'b11, 6'b101010);
    do_write(8'h12, 16'hA5C3, 1'b1);
    do_read(8'h12, 16'hA5C3, "R1 R4 read after write", 0);

    do_write(8'h00, 16'h0001, 1'b1);
    do_write(8'hFF, 16'h8000, 1'b1);
    do_write(8'h7E, 16'h5A5A, 1'b1);
    do_read(8'h00, 16'h0001, "R4 word 00", 0);
    do_read(8'hFF, 16'h8000, "R4 word FF", 0);
    do_read(8'h7E, 16'h5A5A, "R4 word 7E", 0);

    // R5 erase one word
    header(2'b11, 8'h00, s);
    cs_off();
    wait_ready("R7 erase", 1'b1);
    do_read(8'h00, 16'hFFFF, "R5 erased word", 0);
    do_read(8'hFF, 16'h8000, "R5 neighbour kept", 0);

    // R8 disable blocks programming
    do_ext(2'b00, 6'b111111);
    do_write(8'h12, 16'h1111, 1'b0);
    header(2'b11, 8'hFF, s);
    cs_off();
    do_ext(2'b10, 6'b000000);
    do_read(8'h12, 16'hA5C3, "R8 locked write", 0);
    do_read(8'hFF, 16'h8000, "R8 locked erase", 0);
    do_read(8'h7E, 16'h5A5A, "R8 locked erase all", 0);

    // R9 abort mid instruction
    do_ext(2'b11, 6'b010101);
    header(2'b01, 8'h7E, s);
    send_data(16'h0F0F, 10);
    cs_off();
    do_read(8'h7E, 16'h5A5A, "R9 aborted write", 0);

    // R6 extra rise after the last data bit cancels
    header(2'b01, 8'h7E, s);
    send_data(16'h0F0F, 16);
    bit_out(1'b0, s);
    cs_off();
    do_read(8'h7E, 16'h5A5A, "R6 late chip-select", 0);

    // R10 instruction during busy is ignored
    do_write(8'h40, 16'hC0DE, 1'b1);
    header(2'b01, 8'h40, s);
    send_data(16'hBEEF, 16);
    cs_off();
    header(2'b01, 8'h40, s);
    send_data(16'h0000, 16);
    cs_off();
    wait_ready("R10 still busy", 1'b0);
    do_read(8'h40, 16'hBEEF, "R10 ignored while busy", 0);

    // R5 write all, erase all
    header(2'b00, 8'h40, s);
    send_data(16'h3C5A, 16);
    cs_off();
    wait_ready("R7 write all", 1'b1);
    do_read(8'h00, 16'h3C5A, "R5 write all 00", 0);
    do_read(8'hFF, 16'h3C5A, "R5 write all FF", 0);
    do_read(8'h12, 16'h3C5A, "R5 write all 12", 0);
    header(2'b00, 8'h80, s);
    cs_off();
    wait_ready("R7 erase all", 1'b1);
    do_read(8'h40, 16'hFFFF, "R5 erase all 40", 0);
    do_read(8'h7E, 16'hFFFF, "R5 erase all 7E", 0);

    // R1 leading zeros before the start bit
    do_ext(2'b11, 6'b000000);
    do_write(8'h33, 16'h6D29, 1'b1);
    do_read(8'h33, 16'h6D29, "R1 leading zeros", 3);

    repeat (10) @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 32'h0);
    finish_run();
  end

endmodule